// File: doc/BRIEF.md
# Write-Per-Bit Mask and Color Register Controller

This block decides which of the four data bits of a DRAM port may be written in each access. It watches the row strobe, column strobe, write strobe and a special-function select, all active low except the select, sampled on a system clock. On every row-strobe fall it decides three things. It decides whether bit masking applies to the access. It decides whether the mask register is reloaded from the data pins. It records the select level that later tells a normal write from a color-register load.

Once both the column strobe and the write strobe have fallen, the block captures the data pins. The capture happens at whichever of the two falls comes later. A normal write produces a one-clock write strobe with the write-enable vector and the data. A color-register load instead updates the stored 4-bit color value and raises no write strobe. The same pins carry the mask at the row edge and the data later. The mask can serve a single access or persist across many accesses.

Top module: `wpb_mask_ctrl`

## Requirements
- R1: After reset the write strobe and the write-enable vector are 0, the color register is 0, and the mask register holds all ones, so a masked access that keeps the mask enables all four bits.
- R2: When the write strobe is high (we_n=1) at the row-strobe fall, the access writes all four bits (wr_en_o = 4'b1111).
- R3: When we_n=0 and dsf=0 at the row-strobe fall, the mask register is loaded from dq_i at that clock, and the access uses the new mask.
- R4: When we_n=0 and dsf=1 at the row-strobe fall, the mask register is not changed and the access uses the mask from the last reload. The dq_i value at that edge has no effect.
- R5: In a masked access, wr_en_o bit i equals mask bit i: a 1 lets bit i be written and a 0 blocks it. Outside a write strobe, wr_en_o is 0.
- R6: Data is captured in the first clock, after the row-strobe fall, in which both cas_n and we_n are low and cas_n has fallen during the access. wr_data_o shows dq_i from that clock and wr_stb_o is high in the next clock.
- R7: wr_stb_o is high for exactly one clock, at most once per row-strobe low period.
- R8: When dsf=1 both at the row-strobe fall and at the column-strobe fall, the capture loads dq_i into the color register and raises no write strobe.
- R9: The color register changes only on such a load access. Normal writes leave it unchanged.
- R10: If cas_n is already low at the row-strobe fall, nothing is captured during that row-strobe low period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all strobes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| dsf | input | 1 | Special-function select |
| dq_i | input | 4 | Data pins: the mask at the row edge, then the data or color value |
| wr_stb_o | output | 1 | One-clock pulse for a captured normal write |
| wr_en_o | output | 4 | Per-bit write enables, valid with wr_stb_o |
| wr_data_o | output | 4 | Captured write data |
| color_o | output | 4 | Color register contents |

## Verification
The bench drives full row-strobe accesses that differ in four ways: the write-strobe and select levels at the row edge, the select level at the column edge, which strobe falls last, and whether the column strobe leads the row strobe. The cases cover an unmasked write, a reloaded mask, a kept mask with misleading pins at the row edge, and a late write whose data differs from the pins at the column fall. They also cover a color load and an access that leads with the column strobe. Together these separate the reload path from the keep path, show which strobe sets the capture clock, and show that a color load never becomes a write. A behavioural model is compared with every output on every clock.

// File: rtl/wpb_pkg.sv
package wpb_pkg;

    localparam int unsigned WPB_DQ_W = 4;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_OPEN = 2'd1,
        PH_DONE = 2'd2
    } wpb_phase_e;

    typedef struct packed {
        wpb_phase_e            phase;
        logic                  masked;
        logic                  dsf_row;
        logic                  dsf_col;
        logic                  col_seen;
        logic [WPB_DQ_W-1:0]   mask;
        logic [WPB_DQ_W-1:0]   color;
        logic [WPB_DQ_W-1:0]   wr_en;
        logic [WPB_DQ_W-1:0]   wr_data;
        logic                  wr_stb;
    } wpb_state_t;

endpackage

// File: rtl/wpb_fall_detect.sv
module wpb_fall_detect #(
    parameter int unsigned N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl_n,
    output logic [N-1:0] fall
);
    logic [N-1:0] prev_d, prev_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_comb begin
            prev_d[i] = lvl_n[i];
            fall[i]   = prev_q[i] & ~lvl_n[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/wpb_row_decode.sv
module wpb_row_decode (
    input  logic we_n,
    input  logic dsf,
    output logic masked,
    output logic reload
);
    always_comb begin
        masked = ~we_n;
        reload = ~we_n & ~dsf;
    end
endmodule

// File: rtl/wpb_mask_ctrl.sv
module wpb_mask_ctrl
    import wpb_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ras_n,
    input  logic                cas_n,
    input  logic                we_n,
    input  logic                dsf,
    input  logic [WPB_DQ_W-1:0] dq_i,
    output logic                wr_stb_o,
    output logic [WPB_DQ_W-1:0] wr_en_o,
    output logic [WPB_DQ_W-1:0] wr_data_o,
    output logic [WPB_DQ_W-1:0] color_o
);
    localparam int unsigned NSTB = 3;
    localparam int unsigned IDX_RAS = 0;
    localparam int unsigned IDX_CAS = 1;
    localparam int unsigned IDX_WE  = 2;

    wpb_state_t s_d, s_q;

    logic [NSTB-1:0] strobes_n, falls;
    logic            dec_masked, dec_reload;
    logic            capture, dsf_col_eff, col_fall_open;

    assign strobes_n = {we_n, cas_n, ras_n};

    wpb_fall_detect #(.N(NSTB)) u_fall (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl_n (strobes_n),
        .fall  (falls)
    );

    wpb_row_decode u_dec (
        .we_n   (we_n),
        .dsf    (dsf),
        .masked (dec_masked),
        .reload (dec_reload)
    );

    always_comb begin
        s_d        = s_q;
        s_d.wr_stb = 1'b0;
        s_d.wr_en  = '0;

        col_fall_open = falls[IDX_CAS] & (s_q.phase == PH_OPEN);
        dsf_col_eff   = col_fall_open ? dsf : s_q.dsf_col;
        capture       = (s_q.phase == PH_OPEN) & ~cas_n & ~we_n
                      & (s_q.col_seen | col_fall_open);

        if (ras_n) begin
            s_d.phase    = PH_IDLE;
            s_d.col_seen = 1'b0;
        end else if (falls[IDX_RAS]) begin
            s_d.phase    = PH_OPEN;
            s_d.masked   = dec_masked;
            s_d.dsf_row  = dsf;
            s_d.col_seen = 1'b0;
            if (dec_reload) s_d.mask = dq_i;
        end else begin
            if (col_fall_open) begin
                s_d.col_seen = 1'b1;
                s_d.dsf_col  = dsf;
            end
            if (capture) begin
                s_d.phase = PH_DONE;
                if (s_q.dsf_row & dsf_col_eff) begin
                    s_d.color = dq_i;
                end else begin
                    s_d.wr_stb  = 1'b1;
                    s_d.wr_en   = s_q.masked ? s_q.mask : '1;
                    s_d.wr_data = dq_i;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.phase    <= PH_IDLE;
            s_q.masked   <= 1'b0;
            s_q.dsf_row  <= 1'b0;
            s_q.dsf_col  <= 1'b0;
            s_q.col_seen <= 1'b0;
            s_q.mask     <= '1;
            s_q.color    <= '0;
            s_q.wr_en    <= '0;
            s_q.wr_data  <= '0;
            s_q.wr_stb   <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign wr_stb_o  = s_q.wr_stb;
    assign wr_en_o   = s_q.wr_en;
    assign wr_data_o = s_q.wr_data;
    assign color_o   = s_q.color;

    logic unused_we_fall;
    assign unused_we_fall = falls[IDX_WE];
endmodule

// File: rtl/wpb_mask_ctrl_chk.sv
module wpb_mask_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ras_n,
    input logic       cas_n,
    input logic       we_n,
    input logic       wr_stb_o,
    input logic [3:0] wr_en_o,
    input logic [3:0] color_o
);
    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_o |=> !wr_stb_o); // R7

    AST_STB_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_o |-> $past(!ras_n && !cas_n && !we_n)); // R6

    AST_EN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb_o |-> (wr_en_o == 4'b0000)); // R5

    AST_COLOR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (color_o != $past(color_o)) |-> !wr_stb_o); // R8

    AST_COLOR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (color_o != $past(color_o)) |-> $past(!ras_n && !cas_n && !we_n)); // R9
endmodule

bind wpb_mask_ctrl wpb_mask_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .we_n     (we_n),
    .wr_stb_o (wr_stb_o),
    .wr_en_o  (wr_en_o),
    .color_o  (color_o)
);

// File: tb/wpb_mask_ctrl_test.sv
`timescale 1ns/1ps
module wpb_mask_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, dsf = 1'b0;
    logic [3:0] dq = 4'h0;
    logic       wr_stb_o;
    logic [3:0] wr_en_o, wr_data_o, color_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    wpb_mask_ctrl uut (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .dsf(dsf), .dq_i(dq), .wr_stb_o(wr_stb_o), .wr_en_o(wr_en_o),
        .wr_data_o(wr_data_o), .color_o(color_o)
    );

    // behavioural reference: phase 0 idle, 1 row open, 2 column fell, 3 finished
    int         m_phase = 0;
    bit         m_masked, m_dsf_row, m_dsf_col;
    bit         p_ras = 1, p_cas = 1;
    logic [3:0] m_mask = 4'hF, m_color = 0, m_en = 0, m_data = 0;
    bit         m_stb = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_mask = 4'hF; m_color = 0; m_en = 0; m_data = 0;
            m_stb = 0; p_ras = 1; p_cas = 1;
        end else begin
            m_stb = 0; m_en = 0;
            if (ras_n) m_phase = 0;
            else if (p_ras && !ras_n) begin
                m_phase = 1; m_masked = !we_n; m_dsf_row = dsf;
                if (!we_n && !dsf) m_mask = dq;
            end else begin
                if (m_phase == 1 && p_cas && !cas_n) begin
                    m_phase = 2; m_dsf_col = dsf;
                end
                if (m_phase == 2 && !cas_n && !we_n) begin
                    m_phase = 3;
                    if (m_dsf_row && m_dsf_col) m_color = dq;
                    else begin
                        m_stb = 1; m_data = dq;
                        m_en = m_masked ? m_mask : 4'hF;
                    end
                end
            end
            p_ras = ras_n; p_cas = cas_n;
        end
    end

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) if (rst_n) begin
        check("R7 strobe vs model", {3'b0, wr_stb_o}, {3'b0, m_stb});
        check("R5 enables vs model", wr_en_o, m_en);
        check("R6 data vs model", wr_data_o, m_data);
        check("R9 color vs model", color_o, m_color);
    end

    int         n_stb = 0;
    logic [3:0] last_en = 0, last_data = 0;
    always @(negedge clk) if (wr_stb_o) begin
        n_stb++; last_en = wr_en_o; last_data = wr_data_o;
    end

    task automatic access(input bit we_row, input bit dsf_row, input logic [3:0] dq_row,
                          input bit dsf_col, input logic [3:0] data,
                          input bit late, input bit cbr);
        @(negedge clk); we_n = we_row; dsf = dsf_row; dq = dq_row; if (cbr) cas_n = 0;
        @(negedge clk); ras_n = 0;
        @(negedge clk); @(negedge clk);
        dsf = dsf_col; dq = late ? ~data : data;
        if (!cbr) cas_n = 0;
        if (!late) we_n = 0;
        @(negedge clk); @(negedge clk);
        if (late) begin dq = data; we_n = 0; end
        repeat (3) @(negedge clk);
        ras_n = 1; cas_n = 1; we_n = 1; dsf = 0; dq = 0;
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_up;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_up();
    end

    initial begin
        int s0;
        repeat (3) @(negedge clk);
        check("R1 reset strobe", {3'b0, wr_stb_o}, 4'h0);
        check("R1 reset enables", wr_en_o, 4'h0);
        check("R1 reset color", color_o, 4'h0);
        rst_n = 1;
        @(negedge clk);

        // kept mask straight after reset: all ones
        s0 = n_stb;
        access(0, 1, 4'h2, 0, 4'h6, 0, 0);
        check("R1 strobes", 4'(n_stb - s0), 4'h1);
        check("R1 kept reset mask", last_en, 4'hF);

        // reload mask 1010
        s0 = n_stb;
        access(0, 0, 4'hA, 0, 4'h5, 0, 0);
        check("R7 one strobe per access", 4'(n_stb - s0), 4'h1);
        check("R3 reloaded mask", last_en, 4'hA);
        check("R5 data with mask", last_data, 4'h5);

        // persistent: pins at row edge 0011 must not load
        access(0, 1, 4'h3, 0, 4'h9, 0, 0);
        check("R4 mask kept", last_en, 4'hA);

        // unmasked write ignores stored mask
        access(1, 0, 4'h0, 0, 4'hC, 0, 0);
        check("R2 all bits", last_en, 4'hF);
        check("R2 data", last_data, 4'hC);

        // late write: data taken at write-strobe fall
        access(1, 0, 4'h0, 0, 4'h7, 1, 0);
        check("R6 late data", last_data, 4'h7);

        // color load
        s0 = n_stb;
        access(1, 1, 4'h0, 1, 4'hB, 0, 0);
        check("R8 no strobe", 4'(n_stb - s0), 4'h0);
        check("R8 color loaded", color_o, 4'hB);

        // normal write keeps color
        access(0, 0, 4'h5, 0, 4'hE, 0, 0);
        check("R9 color held", color_o, 4'hB);
        check("R5 mask 0101", last_en, 4'h5);

        // dsf high at row only: masked persistent write, not a load
        s0 = n_stb;
        access(0, 1, 4'hF, 0, 4'h1, 0, 0);
        check("R8 row-only dsf writes", 4'(n_stb - s0), 4'h1);
        check("R4 mask still 0101", last_en, 4'h5);
        check("R9 color after row-only dsf", color_o, 4'hB);

        // column strobe leads row strobe
        s0 = n_stb;
        access(0, 0, 4'hF, 0, 4'h8, 0, 1);
        check("R10 no capture", 4'(n_stb - s0), 4'h0);

        repeat (3) @(negedge clk);
        finish_up();
    end
endmodule